// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block decides when a small processor core and its surroundings get a clock, and when the oscillator and flash macro are powered. Software requests one of two saving states with a single write. The write carries an idle bit and a power-down bit. In idle the core clock stops, but the peripheral clock keeps running, so the timers, the PWM timer and the serial port carry on. The comparator enable drops while idle. In power-down the oscillator and flash enables fall as well.

Idle ends on any enabled interrupt request. Power-down ends on a qualifying external interrupt line or an enabled GPIO wake request. Either state also ends on a reset. When the CPU is released by a wake event, the block emits a one-cycle wake pulse so that the pending interrupt is serviced at once. The wake from power-down takes one of two forms. In the timed form, a counter holds the core for a fixed number of cycles. In the pin-released form, the core waits until the waking pin returns high. A guard counter refuses power-down requests for a programmable number of cycles after any reset release and after each exit from power-down.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, cpu_clk_en, per_clk_en, cmp_en, osc_en, flash_en and ready are 1, and mode_idle, mode_pd and wake_pulse are 0.
- R2: A write (ctl_wr=1) with ctl_idle=1 and ctl_pd=0 sets the following from the next cycle: mode_idle=1, cpu_clk_en=0 and cmp_en=0. per_clk_en, osc_en and flash_en stay 1.
- R3: In idle, any bit set in both irq_req and irq_en returns the block to run at the next edge. mode_idle clears and wake_pulse is 1 for exactly that first run cycle. Requests whose irq_en bit is 0 leave idle unchanged.
- R4: An accepted power-down write sets mode_pd=1 from the next cycle and clears osc_en, flash_en, cpu_clk_en, per_clk_en and ready. When ctl_idle and ctl_pd are both 1 in one write, power-down is taken.
- R5: In power-down, external line i wakes only when xint_en[i]=1, xint_level[i]=1 (1 = level-sensitive) and xint_n[i]=0 (active low). An edge-configured line or a disabled line holding low leaves osc_en at 0.
- R6: For the two upper lines (indices 2 and 3), a set vec_reassign bit (bit 0 for line 2, bit 1 for line 3) removes the level-configuration condition. The line then wakes on xint_en=1 and a low pin. With vec_reassign clear, the line follows R5.
- R7: In power-down, any bit set in both gpio_wake and gpio_wake_en wakes the block.
- R8: With wake_sel=0, osc_en and flash_en return at the edge that first samples the wake condition. cpu_clk_en returns WAKE_CYC cycles later, together with a one-cycle wake_pulse.
- R9: With wake_sel=1, osc_en returns at the wake edge. cpu_clk_en stays 0 while any wake source is still active. It returns, with wake_pulse, at the first edge that samples all wake sources released.
- R10: Power-down requests are ignored for GUARD_CYC cycles after reset release (rst_n or ext_rst) and after every power-down exit. A refused write that also has ctl_idle=1 enters idle.
- R11: ext_rst=1 returns the block from any state to run at the next edge without a wake_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst | input | 1 | External reset, synchronous, active high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_idle | input | 1 | Idle request bit of the write |
| ctl_pd | input | 1 | Power-down request bit of the write |
| wake_sel | input | 1 | 0: timed wake, 1: pin-released wake |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Interrupt enables |
| xint_n | input | N_XINT | External interrupt pins, active low |
| xint_en | input | N_XINT | External interrupt enables |
| xint_level | input | N_XINT | 1 = level-sensitive |
| vec_reassign | input | N_SHARED | Upper lines whose vector serves another source |
| gpio_wake | input | N_GPIO | GPIO wake requests |
| gpio_wake_en | input | N_GPIO | GPIO wake enables |
| cpu_clk_en | output | 1 | Core clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| cmp_en | output | 1 | Analog comparator enable |
| osc_en | output | 1 | Oscillator enable |
| flash_en | output | 1 | Flash power enable |
| wake_pulse | output | 1 | One cycle on CPU release by a wake event |
| ready | output | 1 | Oscillator running and settled |
| mode_idle | output | 1 | Self-clearing idle bit |
| mode_pd | output | 1 | Self-clearing power-down bit |

## Verification
The embedded properties check four things on every cycle. The oscillator may only fall when the guard counter had expired and a power-down write was present. The wake pulse never lasts two cycles. Idle only ends on an enabled interrupt or a reset. The core stays gated while a held wake source remains active. Which line combinations qualify for a wake, the exact cycle count of the timed wake, and the refusal of requests right after reset and after wake-up can only be shown by the bench's scenarios.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_PD    = 3'd2,
        ST_WTIME = 3'd3,
        ST_WHOLD = 3'd4
    } pm_state_e;

    typedef struct packed {
        pm_state_e state;
        logic      pulse;
    } pm_regs_t;
endpackage

// File: rtl/pwr_dcnt.sv
module pwr_dcnt #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    AST_CNT_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R10
endmodule

// File: rtl/pwr_wake_src.sv
module pwr_wake_src #(
    parameter int N_XINT   = 4,
    parameter int N_SHARED = 2,
    parameter int N_GPIO   = 2
) (
    input  logic [N_XINT-1:0]   xint_n,
    input  logic [N_XINT-1:0]   xint_en,
    input  logic [N_XINT-1:0]   xint_level,
    input  logic [N_SHARED-1:0] vec_reassign,
    input  logic [N_GPIO-1:0]   gpio_wake,
    input  logic [N_GPIO-1:0]   gpio_wake_en,
    output logic                wake_any
);
    localparam int FIRST_SHARED = N_XINT - N_SHARED;

    logic [N_XINT-1:0] line_ok;

    for (genvar i = 0; i < N_XINT; i++) begin : g_line
        if (i >= FIRST_SHARED) begin : g_shared
            assign line_ok[i] = xint_en[i] & ~xint_n[i] &
                                (xint_level[i] | vec_reassign[i-FIRST_SHARED]);
        end else begin : g_plain
            assign line_ok[i] = xint_en[i] & ~xint_n[i] & xint_level[i];
        end
    end

    assign wake_any = (|line_ok) | (|(gpio_wake & gpio_wake_en));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int N_IRQ     = 4,
    parameter int N_XINT    = 4,
    parameter int N_SHARED  = 2,
    parameter int N_GPIO    = 2,
    parameter int WAKE_CYC  = 64,
    parameter int GUARD_CYC = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_rst,
    input  logic                ctl_wr,
    input  logic                ctl_idle,
    input  logic                ctl_pd,
    input  logic                wake_sel,
    input  logic [N_IRQ-1:0]    irq_req,
    input  logic [N_IRQ-1:0]    irq_en,
    input  logic [N_XINT-1:0]   xint_n,
    input  logic [N_XINT-1:0]   xint_en,
    input  logic [N_XINT-1:0]   xint_level,
    input  logic [N_SHARED-1:0] vec_reassign,
    input  logic [N_GPIO-1:0]   gpio_wake,
    input  logic [N_GPIO-1:0]   gpio_wake_en,
    output logic                cpu_clk_en,
    output logic                per_clk_en,
    output logic                cmp_en,
    output logic                osc_en,
    output logic                flash_en,
    output logic                wake_pulse,
    output logic                ready,
    output logic                mode_idle,
    output logic                mode_pd
);
    localparam int WT_W = $clog2(WAKE_CYC + 1);
    localparam int GD_W = $clog2(GUARD_CYC + 1);
    localparam logic [WT_W-1:0] WT_LOAD = WT_W'(WAKE_CYC - 1);
    localparam logic [GD_W-1:0] GD_LOAD = GD_W'(GUARD_CYC - 1);

    pm_regs_t r_d, r_q;
    logic wake_any, irq_any, pd_ok;
    logic wt_load, wt_done, gd_load, gd_done;

    pwr_wake_src #(
        .N_XINT(N_XINT), .N_SHARED(N_SHARED), .N_GPIO(N_GPIO)
    ) u_wake (
        .xint_n(xint_n), .xint_en(xint_en), .xint_level(xint_level),
        .vec_reassign(vec_reassign), .gpio_wake(gpio_wake),
        .gpio_wake_en(gpio_wake_en), .wake_any(wake_any)
    );

    pwr_dcnt #(.W(WT_W), .RST_VAL('0)) u_wake_tmr (
        .clk(clk), .rst_n(rst_n), .load(wt_load),
        .load_val(WT_LOAD), .done(wt_done)
    );

    pwr_dcnt #(.W(GD_W), .RST_VAL(GD_LOAD)) u_guard (
        .clk(clk), .rst_n(rst_n), .load(gd_load),
        .load_val(GD_LOAD), .done(gd_done)
    );

    assign irq_any = |(irq_req & irq_en);
    assign pd_ok   = ctl_wr & ctl_pd & gd_done;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        wt_load   = 1'b0;
        gd_load   = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                if (pd_ok)
                    r_d.state = ST_PD;
                else if (ctl_wr && ctl_idle)
                    r_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_any) begin
                    r_d.state = ST_RUN;
                    r_d.pulse = 1'b1;
                end
            end
            ST_PD: begin
                if (wake_any) begin
                    wt_load   = 1'b1;
                    r_d.state = wake_sel ? ST_WHOLD : ST_WTIME;
                end
            end
            ST_WTIME: begin
                if (wt_done) begin
                    r_d.state = ST_RUN;
                    r_d.pulse = 1'b1;
                    gd_load   = 1'b1;
                end
            end
            ST_WHOLD: begin
                if (!wake_any) begin
                    r_d.state = ST_RUN;
                    r_d.pulse = 1'b1;
                    gd_load   = 1'b1;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
        if (ext_rst) begin
            r_d.state = ST_RUN;
            r_d.pulse = 1'b0;
            wt_load   = 1'b0;
            gd_load   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_RUN, pulse: 1'b0};
        else        r_q <= r_d;
    end

    assign cpu_clk_en = (r_q.state == ST_RUN);
    assign per_clk_en = (r_q.state == ST_RUN) || (r_q.state == ST_IDLE);
    assign cmp_en     = (r_q.state == ST_RUN);
    assign osc_en     = (r_q.state != ST_PD);
    assign flash_en   = (r_q.state != ST_PD);
    assign ready      = per_clk_en;
    assign mode_idle  = (r_q.state == ST_IDLE);
    assign mode_pd    = (r_q.state == ST_PD) || (r_q.state == ST_WTIME) ||
                        (r_q.state == ST_WHOLD);
    assign wake_pulse = r_q.pulse;

    AST_OSC_OFF_NEEDS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(gd_done)); // R10
    AST_FLASH_OFF_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_en) |-> $past(ctl_wr && ctl_pd)); // R4
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R3
    AST_IDLE_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_idle) && !mode_idle) |-> ($past(irq_any) || $past(ext_rst))); // R3
    AST_HOLD_KEEPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WHOLD && wake_any && !ext_rst) |=> !cpu_clk_en); // R9
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int WCYC = 6;
    localparam int GCYC = 20;

    logic clk = 1'b0, rst_n = 1'b0, ext_rst = 1'b0;
    logic ctl_wr = 1'b0, ctl_idle = 1'b0, ctl_pd = 1'b0, wake_sel = 1'b0;
    logic [3:0] irq_req = '0, irq_en = '0;
    logic [3:0] xint_n = '1, xint_en = '0, xint_level = '0;
    logic [1:0] vec_reassign = '0, gpio_wake = '0, gpio_wake_en = '0;
    logic cpu_clk_en, per_clk_en, cmp_en, osc_en, flash_en;
    logic wake_pulse, ready, mode_idle, mode_pd;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.WAKE_CYC(WCYC), .GUARD_CYC(GCYC)) dut (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .ctl_wr(ctl_wr),
        .ctl_idle(ctl_idle), .ctl_pd(ctl_pd), .wake_sel(wake_sel),
        .irq_req(irq_req), .irq_en(irq_en), .xint_n(xint_n),
        .xint_en(xint_en), .xint_level(xint_level),
        .vec_reassign(vec_reassign), .gpio_wake(gpio_wake),
        .gpio_wake_en(gpio_wake_en), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .cmp_en(cmp_en), .osc_en(osc_en),
        .flash_en(flash_en), .wake_pulse(wake_pulse), .ready(ready),
        .mode_idle(mode_idle), .mode_pd(mode_pd)
    );

    // fields: pins_n[4] en[4] level[4] reassign[2] gpio[2] gpio_en[2] expect[1]
    localparam int NV = 9;
    localparam logic [18:0] VEC [NV] = '{
        {4'b1110, 4'b0001, 4'b0001, 2'b00, 2'b00, 2'b00, 1'b1}, // line0 level, R5
        {4'b1101, 4'b0010, 4'b0000, 2'b00, 2'b00, 2'b00, 1'b0}, // line1 edge, R5
        {4'b1101, 4'b0000, 4'b0010, 2'b00, 2'b00, 2'b00, 1'b0}, // line1 off, R5
        {4'b1011, 4'b0100, 4'b0000, 2'b01, 2'b00, 2'b00, 1'b1}, // line2 shared, R6
        {4'b0111, 4'b1000, 4'b0000, 2'b00, 2'b00, 2'b00, 1'b0}, // line3 edge, R6
        {4'b0111, 4'b1000, 4'b0000, 2'b10, 2'b00, 2'b00, 1'b1}, // line3 shared, R6
        {4'b0111, 4'b0000, 4'b0000, 2'b10, 2'b00, 2'b00, 1'b0}, // line3 off, R6
        {4'b1111, 4'b0000, 4'b0000, 2'b00, 2'b10, 2'b10, 1'b1}, // gpio1, R7
        {4'b1111, 4'b0000, 4'b0000, 2'b00, 2'b01, 2'b10, 1'b0}  // gpio0 masked, R7
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic idle_b, logic pd_b);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_idle = idle_b; ctl_pd = pd_b;
        tick();
        ctl_wr = 1'b0; ctl_idle = 1'b0; ctl_pd = 1'b0;
    endtask

    task automatic do_ext_rst();
        @(negedge clk); ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        #9 rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 enables", {cpu_clk_en, per_clk_en, cmp_en, osc_en, flash_en, ready}, 6'b111111);
        chk("R1 flags", {mode_idle, mode_pd, wake_pulse}, 3'b000);

        // R10 power-down refused right after reset release
        wr(1'b0, 1'b1);
        chk("R10 pd refused after reset", {mode_pd, osc_en}, 2'b01);
        wr(1'b1, 1'b1);
        chk("R10 refused pd falls to idle", {mode_idle, mode_pd}, 2'b10);
        do_ext_rst();
        chk("R11 ext reset leaves idle", {mode_idle, cpu_clk_en, wake_pulse}, 3'b010);

        // R2 / R3 idle
        wr(1'b1, 1'b0);
        chk("R2 idle gates", {mode_idle, cpu_clk_en, cmp_en, per_clk_en, osc_en, flash_en}, 6'b100111);
        @(negedge clk); irq_req = 4'b0100; irq_en = 4'b0010;
        wait_cyc(3);
        chk("R3 masked irq ignored", mode_idle, 1'b1);
        @(negedge clk); irq_en = 4'b0110;
        tick();
        chk("R3 idle exit", {mode_idle, cpu_clk_en, wake_pulse}, 3'b011);
        tick();
        chk("R3 pulse one cycle", wake_pulse, 1'b0);
        irq_req = '0; irq_en = '0;

        // R4 both bits: power-down wins (guard long expired)
        wait_cyc(GCYC);
        wr(1'b1, 1'b1);
        chk("R4 pd priority", {mode_pd, mode_idle, osc_en, flash_en, cpu_clk_en, per_clk_en, ready}, 7'b1000000);

        // R8 timed wake on line 0
        @(negedge clk); xint_en = 4'b0001; xint_level = 4'b0001; xint_n = 4'b1110;
        tick();
        chk("R8 osc back at wake edge", {osc_en, flash_en, cpu_clk_en}, 3'b110);
        n = 1;
        while (!cpu_clk_en && n < 50) begin tick(); n++; end
        chk("R8 timed wake length", n, WCYC + 1);
        chk("R8 pulse with release", {wake_pulse, mode_pd}, 2'b10);
        @(negedge clk); xint_n = '1;
        // R10 refused right after power-down exit
        wr(1'b0, 1'b1);
        chk("R10 pd refused after wake", {mode_pd, osc_en}, 2'b01);

        // R9 pin-released wake
        wait_cyc(GCYC);
        wake_sel = 1'b1;
        wr(1'b0, 1'b1);
        chk("R9 pd entered", mode_pd, 1'b1);
        @(negedge clk); xint_n = 4'b1110;
        tick();
        chk("R9 osc up, cpu gated", {osc_en, cpu_clk_en}, 2'b10);
        wait_cyc(WCYC + 4);
        chk("R9 held while pin low", {cpu_clk_en, mode_pd}, 2'b01);
        @(negedge clk); xint_n = '1;
        tick();
        chk("R9 release on pin high", {cpu_clk_en, wake_pulse}, 2'b11);
        wake_sel = 1'b0; xint_en = '0; xint_level = '0;

        // R11 ext reset from power-down, no pulse
        wait_cyc(GCYC);
        wr(1'b0, 1'b1);
        do_ext_rst();
        chk("R11 ext reset leaves pd", {mode_pd, cpu_clk_en, wake_pulse}, 3'b010);

        // R5 R6 R7 wake qualification table
        for (int v = 0; v < NV; v++) begin
            wait_cyc(GCYC + 1);
            wr(1'b0, 1'b1);
            chk("R4 pd entry in table", mode_pd, 1'b1);
            @(negedge clk);
            {xint_n, xint_en, xint_level, vec_reassign, gpio_wake, gpio_wake_en} = VEC[v][18:1];
            wait_cyc(3);
            chk(v < 3 ? "R5 line qualify" : (v < 7 ? "R6 shared line" : "R7 gpio wake"),
                osc_en, VEC[v][0]);
            @(negedge clk);
            xint_n = '1; xint_en = '0; xint_level = '0; vec_reassign = '0;
            gpio_wake = '0; gpio_wake_en = '0;
            do_ext_rst();
        end

        finish_run();
    end
endmodule